// File: doc/BRIEF.md
# Two-stage line resizer

This block rescales one line of 8-bit pixels from an input length to a different output length. A coefficient calculator takes the two lengths and decides how many halving passes to apply (zero, one or two), and which fixed-point step the interpolator should use. It rejects any request that the hardware cannot serve. The pixel path has two parts. First come up to two halving stages, each of which replaces a pair of neighbouring pixels with their rounded mean. After them comes a linear interpolator that moves a position accumulator across the shortened line and blends the two pixels on either side of each position.

To use it, software-side control loads a configuration by pulsing `cfg_start` with both lengths. It waits for `cfg_done` and then streams lines. Each line begins with a pixel flagged by `s_sol`. Output pixels leave on a valid/ready stream, and `m_eol` marks the last pixel of each output line.

Back-pressure rules: a pixel transfers on a cycle where valid and ready are both high. Once `m_valid` is raised, it stays high and `m_data`/`m_eol` stay unchanged until `m_ready` accepts them. `s_ready` may depend on `s_sol`. The source must hold `s_valid`, `s_data` and `s_sol` until they are accepted. Holding `m_ready` low stalls the whole pipe back to the input.

Top module: `line_resizer`

## Requirements
- R1: A request whose input length is 0 or above 4096, or whose output length is below 2 or above 1024, ends with `cfg_err` high and `cfg_done` pulsed on the cycle after the start.
- R2: A request where four times the output length is smaller than the input length is rejected with `cfg_err`. Exactly 4:1 is accepted.
- R3: The halving count starts at 0, with the working size equal to the input length. While the count is under 2 and the working size either exceeds 1024 or is at least twice the output length, the working size is halved (floor) and the count goes up by one.
- R4: The step equals floor(8192 × (working size − 1) / (output length − 1)).
- R5: A step that would be 16384 or more is replaced by 16383 (0x3FFF).
- R6: `coef_word` holds the active configuration, with the halving count in bits 15:14 and the step in bits 13:0. After a rejected request it, and the line processing, keep the previously accepted configuration.
- R7: `cfg_done` is a single-cycle pulse that arrives no later than 32 cycles after `cfg_start`.
- R8: Each active halving stage outputs (a + b + 1) >> 1 for consecutive pairs counted from the start-of-line pixel. An unpaired trailing pixel is dropped.
- R9: Output pixel k sits at position p = k × step, with 13 fractional bits. With i = p >> 13 and f = p mod 8192, the value is (x[i]·(8192 − f) + x[i+1]·f + 4096) >> 13 over the prefiltered line x. Here x[i+1] is replaced by x[i] when i is the last prefiltered index.
- R10: Each line yields exactly the configured output length of pixels, with `m_eol` high only on the last one. No pixel appears outside a line.
- R11: While `m_valid` is high and `m_ready` low, `m_valid`, `m_data` and `m_eol` stay unchanged.
- R12: Pixels that arrive before any start-of-line pixel, or after a line's output is complete, produce no output and do not disturb the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Pulse to compute a configuration from the two lengths |
| cfg_in_len | input | 13 | Input line length |
| cfg_out_len | input | 11 | Output line length |
| cfg_done | output | 1 | One-cycle pulse: calculation finished |
| cfg_err | output | 1 | Last request was rejected (valid from `cfg_done`) |
| coef_word | output | 16 | Active halving count (15:14) and step (13:0) |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with `s_valid` |
| s_data | input | 8 | Input pixel |
| s_sol | input | 1 | Input pixel is the first of a line |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts the output pixel |
| m_data | output | 8 | Output pixel |
| m_eol | output | 1 | Output pixel is the last of its line |

## Verification
The bench builds the block with its default parameters: 8-bit pixels, input lengths up to 4096, output lengths up to 1024, and two halving stages. These values expose the exact length limits (4096/1024 accepted, 5000 and 1025 rejected) and the 4:1 edge (400→100 accepted, 401→100 rejected). They also cover a request that uses both halving stages, and a 3→2 request whose step saturates. Short lines of up to 16 pixels run through every halving depth, through upscaling and through saturated downscaling, some with output stalls and input bubbles. A rejected request followed by a line shows that the previous configuration survives. Stray pixels before a line check that they leave no trace.

// File: rtl/line_rsz_pkg.sv
package line_rsz_pkg;
  // coefficient calculator sequencing
  typedef enum logic {
    CALC_IDLE = 1'b0,
    CALC_DIV  = 1'b1
  } calc_state_e;
endpackage

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc
  import line_rsz_pkg::*;
#(
  parameter int IN_W     = 13,
  parameter int OUT_W    = 11,
  parameter int MAX_IN   = 4096,
  parameter int MAX_OUT  = 1024,
  parameter int NUM_HALF = 2,
  parameter int FRAC_W   = 13,
  parameter int STEP_W   = 14,
  parameter int HC_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IN_W-1:0]   in_len,
  input  logic [OUT_W-1:0]  out_len,
  output logic              done,
  output logic              err,
  output logic [HC_W-1:0]   halves,
  output logic [STEP_W-1:0] step,
  output logic [IN_W-1:0]   work_len,
  output logic [OUT_W-1:0]  line_len
);
  localparam int DVD_W = IN_W + FRAC_W;
  localparam int CMP_W = DVD_W + 1;
  localparam int CNT_W = $clog2(STEP_W);

  logic              bad, go, ovf_c, take;
  logic [IN_W-1:0]   w_c;
  logic [HC_W-1:0]   hc_c;
  logic [DVD_W-1:0]  dvd_c;
  logic [CMP_W-1:0]  trial;
  logic [STEP_W-1:0] quo_nx;

  calc_state_e       state;
  logic [DVD_W-1:0]  rem;
  logic [STEP_W-1:0] quo;
  logic [CNT_W-1:0]  cnt;
  logic [OUT_W-1:0]  dvs, ol_r;
  logic [HC_W-1:0]   hc_r;
  logic [IN_W-1:0]   w_r;

  // request screening and prefilter depth selection
  always_comb begin
    bad = (in_len == '0) || (int'(in_len) > MAX_IN) || (int'(out_len) > MAX_OUT) ||
          (out_len < OUT_W'(2)) || (int'(out_len) * 4 < int'(in_len));
    w_c  = in_len;
    hc_c = '0;
    go   = 1'b1;
    for (int i = 0; i < NUM_HALF; i++) begin
      if (go && ((int'(w_c) > MAX_OUT) || (int'(w_c) >= 2 * int'(out_len)))) begin
        w_c  = w_c >> 1;
        hc_c = hc_c + HC_W'(1);
      end else begin
        go = 1'b0;
      end
    end
    dvd_c = {w_c - IN_W'(1), {FRAC_W{1'b0}}};
    ovf_c = CMP_W'(dvd_c) >= (CMP_W'(out_len - OUT_W'(1)) << STEP_W);
  end

  // one quotient bit per cycle, MSB first
  always_comb begin
    trial  = CMP_W'(dvs) << cnt;
    take   = CMP_W'(rem) >= trial;
    quo_nx = quo | (take ? (STEP_W'(1) << cnt) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CALC_IDLE;
      done     <= 1'b0;
      err      <= 1'b0;
      halves   <= '0;
      step     <= '0;
      work_len <= '0;
      line_len <= '0;
      rem      <= '0;
      quo      <= '0;
      cnt      <= '0;
      dvs      <= '0;
      ol_r     <= '0;
      hc_r     <= '0;
      w_r      <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        err <= bad;
        if (bad) begin
          done  <= 1'b1;
          state <= CALC_IDLE;
        end else if (ovf_c) begin
          done     <= 1'b1;
          halves   <= hc_c;
          step     <= '1;
          work_len <= w_c;
          line_len <= out_len;
          state    <= CALC_IDLE;
        end else begin
          state <= CALC_DIV;
          rem   <= dvd_c;
          quo   <= '0;
          cnt   <= CNT_W'(STEP_W - 1);
          dvs   <= out_len - OUT_W'(1);
          hc_r  <= hc_c;
          w_r   <= w_c;
          ol_r  <= out_len;
        end
      end else if (state == CALC_DIV) begin
        if (take) rem <= rem - DVD_W'(trial);
        quo <= quo_nx;
        if (cnt == '0) begin
          state    <= CALC_IDLE;
          done     <= 1'b1;
          halves   <= hc_r;
          step     <= quo_nx;
          work_len <= w_r;
          line_len <= ol_r;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rsz_half_stage.sv
module rsz_half_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sol
);
  logic             half_full, hold_sol, pair_end;
  logic [PIX_W-1:0] hold;
  logic [PIX_W:0]   sum;

  always_comb begin
    pair_end = half_full && !in_sol;
    sum      = {1'b0, hold} + {1'b0, in_data} + (PIX_W + 1)'(1);
    if (en) begin
      out_valid = in_valid && pair_end;
      out_data  = PIX_W'(sum >> 1);
      out_sol   = hold_sol;
      in_ready  = pair_end ? out_ready : 1'b1;
    end else begin
      out_valid = in_valid;
      out_data  = in_data;
      out_sol   = in_sol;
      in_ready  = out_ready;
    end
  end

  // a start-of-line pixel always opens a new pair, dropping any orphan
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_full <= 1'b0;
      hold      <= '0;
      hold_sol  <= 1'b0;
    end else if (!en) begin
      half_full <= 1'b0;
    end else if (in_valid && in_ready) begin
      if (pair_end) begin
        half_full <= 1'b0;
      end else begin
        hold      <= in_data;
        hold_sol  <= in_sol;
        half_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsz_interp.sv
module rsz_interp #(
  parameter int PIX_W  = 8,
  parameter int IDX_W  = 13,
  parameter int OUT_W  = 11,
  parameter int FRAC_W = 13,
  parameter int STEP_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic [IDX_W-1:0]  work_len,
  input  logic [OUT_W-1:0]  out_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_data,
  input  logic              in_sol,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic              m_eol
);
  localparam int POS_W = IDX_W + FRAC_W;
  localparam int BW    = PIX_W + FRAC_W + 1;

  logic              active;
  logic [PIX_W-1:0]  prev, cur;
  logic [IDX_W:0]    have;
  logic [POS_W-1:0]  pos;
  logic [OUT_W-1:0]  emitted;

  logic [IDX_W-1:0]  ip;
  logic [FRAC_W-1:0] frac;
  logic [IDX_W:0]    ip1, ip2;
  logic              pair_ok, tail_ok, can_emit, fire, last;
  logic [PIX_W-1:0]  left;
  logic [FRAC_W:0]   wl, wr;
  logic [BW-1:0]     blend;

  always_comb begin
    ip       = pos[POS_W-1:FRAC_W];
    frac     = pos[FRAC_W-1:0];
    ip1      = {1'b0, ip} + (IDX_W + 1)'(1);
    ip2      = {1'b0, ip} + (IDX_W + 1)'(2);
    pair_ok  = have == ip2;
    tail_ok  = (have == {1'b0, work_len}) && (ip1 == {1'b0, work_len});
    can_emit = active && (pair_ok || tail_ok);
    fire     = can_emit && (!m_valid || m_ready);
    last     = emitted == (out_len - OUT_W'(1));
    in_ready = !active || ((have < ip2) && (have < {1'b0, work_len}));
    left     = pair_ok ? prev : cur;
    wr       = {1'b0, frac};
    wl       = {1'b1, {FRAC_W{1'b0}}} - wr;
    blend    = BW'(left) * BW'(wl) + BW'(cur) * BW'(wr) + BW'(1 << (FRAC_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      prev    <= '0;
      cur     <= '0;
      have    <= '0;
      pos     <= '0;
      emitted <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_eol   <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        if (in_sol) begin
          active  <= 1'b1;
          cur     <= in_data;
          have    <= (IDX_W + 1)'(1);
          pos     <= '0;
          emitted <= '0;
        end else if (active) begin
          prev <= cur;
          cur  <= in_data;
          have <= have + (IDX_W + 1)'(1);
        end
      end
      if (fire) begin
        m_valid <= 1'b1;
        m_data  <= PIX_W'(blend >> FRAC_W);
        m_eol   <= last;
        pos     <= pos + POS_W'(step);
        emitted <= emitted + OUT_W'(1);
        if (last) active <= 1'b0;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/line_resizer.sv
module line_resizer #(
  parameter int PIX_W    = 8,
  parameter int MAX_IN   = 4096,
  parameter int MAX_OUT  = 1024,
  parameter int NUM_HALF = 2,
  parameter int FRAC_W   = 13,
  localparam int IN_W    = $clog2(MAX_IN) + 1,
  localparam int OUT_W   = $clog2(MAX_OUT) + 1,
  localparam int STEP_W  = FRAC_W + 1,
  localparam int HC_W    = $clog2(NUM_HALF + 1),
  localparam int COEF_W  = HC_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [IN_W-1:0]   cfg_in_len,
  input  logic [OUT_W-1:0]  cfg_out_len,
  output logic              cfg_done,
  output logic              cfg_err,
  output logic [COEF_W-1:0] coef_word,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  input  logic              s_sol,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic              m_eol
);
  logic [HC_W-1:0]   act_halves;
  logic [STEP_W-1:0] act_step;
  logic [IN_W-1:0]   act_work_len;
  logic [OUT_W-1:0]  act_out_len;

  logic [NUM_HALF:0] ch_v, ch_r, ch_sol;
  logic [PIX_W-1:0]  ch_d [NUM_HALF+1];

  rsz_coef_calc #(
    .IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT),
    .NUM_HALF(NUM_HALF), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .HC_W(HC_W)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .start(cfg_start),
    .in_len(cfg_in_len), .out_len(cfg_out_len),
    .done(cfg_done), .err(cfg_err),
    .halves(act_halves), .step(act_step),
    .work_len(act_work_len), .line_len(act_out_len)
  );

  assign coef_word = {act_halves, act_step};

  assign ch_v[0]   = s_valid;
  assign ch_d[0]   = s_data;
  assign ch_sol[0] = s_sol;
  assign s_ready   = ch_r[0];

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_half
    rsz_half_stage #(.PIX_W(PIX_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .en(act_halves > HC_W'(g)),
      .in_valid(ch_v[g]), .in_ready(ch_r[g]),
      .in_data(ch_d[g]), .in_sol(ch_sol[g]),
      .out_valid(ch_v[g+1]), .out_ready(ch_r[g+1]),
      .out_data(ch_d[g+1]), .out_sol(ch_sol[g+1])
    );
  end

  rsz_interp #(
    .PIX_W(PIX_W), .IDX_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) u_interp (
    .clk(clk), .rst_n(rst_n),
    .step(act_step), .work_len(act_work_len), .out_len(act_out_len),
    .in_valid(ch_v[NUM_HALF]), .in_ready(ch_r[NUM_HALF]),
    .in_data(ch_d[NUM_HALF]), .in_sol(ch_sol[NUM_HALF]),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_eol(m_eol)
  );
endmodule

// File: rtl/line_resizer_chk.sv
module line_resizer_chk #(
  parameter int PIX_W   = 8,
  parameter int IN_W    = 13,
  parameter int OUT_W   = 11,
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_start,
  input logic [IN_W-1:0]  cfg_in_len,
  input logic [OUT_W-1:0] cfg_out_len,
  input logic             cfg_done,
  input logic             cfg_err,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_data,
  input logic             m_eol,
  input logic [OUT_W-1:0] line_len
);
  logic             pend;
  logic [5:0]       wait_cnt;
  logic [OUT_W-1:0] m_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
      m_cnt    <= '0;
    end else begin
      if (cfg_start) begin
        pend     <= 1'b1;
        wait_cnt <= '0;
      end else if (cfg_done) begin
        pend <= 1'b0;
      end else if (pend && wait_cnt != '1) begin
        wait_cnt <= wait_cnt + 6'd1;
      end
      if (m_valid && m_ready) m_cnt <= m_eol ? '0 : m_cnt + OUT_W'(1);
    end
  end

  // R7
  done_in_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> wait_cnt < 6'd32);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done && !cfg_start |=> !cfg_done);

  // R1
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start && ((int'(cfg_in_len) > MAX_IN) || (int'(cfg_out_len) > MAX_OUT) ||
                  (cfg_out_len < OUT_W'(2)) || (cfg_in_len == '0))
    |=> cfg_done && cfg_err);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_eol));

  // R10
  eol_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_eol |-> m_cnt == line_len - OUT_W'(1));
endmodule

bind line_resizer line_resizer_chk #(
  .PIX_W(PIX_W), .IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
  .cfg_in_len(cfg_in_len), .cfg_out_len(cfg_out_len),
  .cfg_done(cfg_done), .cfg_err(cfg_err),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_eol(m_eol),
  .line_len(act_out_len)
);

// File: tb/line_resizer_test.sv
module line_resizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 8;
  localparam int IN_W   = 13;
  localparam int OUT_W  = 11;
  localparam int COEF_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_start = 1'b0;
  logic [IN_W-1:0]   cfg_in_len = '0;
  logic [OUT_W-1:0]  cfg_out_len = '0;
  logic              cfg_done, cfg_err;
  logic [COEF_W-1:0] coef_word;
  logic              s_valid = 1'b0, s_sol = 1'b0;
  logic [PIX_W-1:0]  s_data = '0;
  logic              s_ready;
  logic              m_valid, m_eol;
  logic              m_ready = 1'b1;
  logic [PIX_W-1:0]  m_data;

  line_resizer uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start),
    .cfg_in_len(cfg_in_len), .cfg_out_len(cfg_out_len),
    .cfg_done(cfg_done), .cfg_err(cfg_err), .coef_word(coef_word),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sol(s_sol),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_eol(m_eol)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_run = 0, n_bad = 0;
  bit finished = 0;
  int g_hc = 0, g_step = 0, g_wl = 0, g_ol = 0;
  int raw [64];
  int pre [64];
  int expv[64];

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  function automatic void ref_calc(input int in_l, input int out_l, output bit e,
                                   output int hc, output int st, output int wl);
    e  = (in_l < 1) || (in_l > 4096) || (out_l < 2) || (out_l > 1024) || (out_l * 4 < in_l);
    wl = in_l; hc = 0; st = 0;
    while (((wl > 1024) || (wl >= 2 * out_l)) && hc < 2) begin
      wl = wl >> 1; hc++;
    end
    if (!e) begin
      st = (8192 * (wl - 1)) / (out_l - 1);
      if (st >= 16384) st = 16383;
    end
  endfunction

  task automatic do_calc(input int in_l, input int out_l, output bit e, output int coef, output int lat);
    @(negedge clk);
    cfg_in_len = IN_W'(in_l); cfg_out_len = OUT_W'(out_l); cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    lat = 1;
    while (!cfg_done && lat < 40) begin @(negedge clk); lat++; end
    e = cfg_err;
    coef = int'(coef_word);
  endtask

  task automatic calc_case(input int in_l, input int out_l, input string req);
    int old, coef, lat, hc, st, wl;
    bit e, ee;
    old = int'(coef_word);
    do_calc(in_l, out_l, e, coef, lat);
    ref_calc(in_l, out_l, ee, hc, st, wl);
    check(lat <= 32, "R7", lat, 32, "done latency");
    check(e == ee, req, int'(e), int'(ee), "error flag");
    if (ee) begin
      check(coef == old, "R6", coef, old, "coef kept after reject");
    end else begin
      check(coef == hc * 16384 + st, req, coef, hc * 16384 + st, "coef word");
      g_hc = hc; g_step = st; g_wl = wl; g_ol = out_l;
    end
  endtask

  task automatic run_line(input int in_l, input int out_l, input int seed, input bit bp,
                          input bit cfg, input string req);
    int len, got;
    if (cfg) calc_case(in_l, out_l, req);
    for (int i = 0; i < in_l; i++) begin
      raw[i] = (i * 37 + seed * 11 + (i * i) % 13) & 255;
      pre[i] = raw[i];
    end
    len = in_l;
    for (int h = 0; h < g_hc; h++) begin
      for (int j = 0; j < len / 2; j++) pre[j] = (pre[2*j] + pre[2*j+1] + 1) >> 1;
      len = len / 2;
    end
    for (int k = 0; k < g_ol; k++) begin
      int p, ip, f, a, b;
      p = k * g_step; ip = p >> 13; f = p & 8191;
      a = pre[ip];
      b = (ip + 1 < len) ? pre[ip+1] : pre[ip];
      expv[k] = (a * (8192 - f) + b * f + 4096) >> 13;
    end
    got = 0;
    fork
      begin
        for (int i = 0; i < in_l; i++) begin
          @(negedge clk);
          if (bp && (i % 5 == 3)) begin s_valid = 1'b0; @(negedge clk); end
          s_valid = 1'b1; s_data = PIX_W'(raw[i]); s_sol = (i == 0);
          #1;
          while (!s_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        s_valid = 1'b0; s_sol = 1'b0;
      end
      begin
        int cyc;
        cyc = 0;
        while (got < g_ol) begin
          @(negedge clk);
          m_ready = bp ? (cyc % 3 != 0) : 1'b1;
          cyc++;
          #1;
          if (m_valid && m_ready) begin
            check(int'(m_data) == expv[got], req, int'(m_data), expv[got], $sformatf("pixel %0d", got));
            check(m_eol == (got == g_ol - 1), "R10", int'(m_eol), int'(got == g_ol - 1), "end marker");
            got++;
          end
        end
        m_ready = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    check(m_valid == 1'b0, "R10", int'(m_valid), 0, "no extra output");
  endtask

  task automatic stray_pixels();
    int seen;
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sol = 1'b0; s_data = PIX_W'(200 + i);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (m_valid) seen++;
    end
    check(seen == 0, "R12", seen, 0, "output from stray pixels");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_valid == 1'b0, "R10", int'(m_valid), 0, "reset m_valid");
    check(cfg_done == 1'b0, "R7", int'(cfg_done), 0, "reset done");
    check(coef_word == '0, "R6", int'(coef_word), 0, "reset coef");

    calc_case(4096, 1024, "R3");
    calc_case(4000, 1000, "R3");
    calc_case(100, 100, "R3");
    calc_case(10, 4, "R4");
    calc_case(2, 1024, "R4");
    calc_case(3, 2, "R5");
    calc_case(5000, 100, "R1");
    calc_case(100, 1025, "R1");
    calc_case(10, 1, "R1");
    calc_case(0, 10, "R1");
    calc_case(401, 100, "R2");
    calc_case(400, 100, "R2");

    run_line(8, 8, 1, 1'b0, 1'b1, "R9");
    run_line(16, 8, 2, 1'b0, 1'b1, "R8");
    run_line(16, 4, 3, 1'b0, 1'b1, "R8");
    run_line(7, 3, 4, 1'b0, 1'b1, "R8");
    run_line(4, 10, 5, 1'b0, 1'b1, "R9");
    run_line(10, 4, 6, 1'b1, 1'b1, "R11");
    run_line(3, 2, 7, 1'b0, 1'b1, "R5");
    run_line(12, 5, 8, 1'b1, 1'b1, "R9");
    calc_case(10, 1, "R1");
    run_line(12, 5, 9, 1'b0, 1'b0, "R6");
    stray_pixels();
    run_line(12, 5, 10, 1'b0, 1'b0, "R12");
    run_line(9, 16, 11, 1'b1, 1'b1, "R9");

    finish_run();
  end
endmodule